// File: doc/BRIEF.md
# Dual-Format Parallel Register Host Port

This block is a slave-side host port. It lets an external microprocessor read and write a bank of thirty-two 8-bit control registers over an 8-bit bus. Two static strap inputs set the bus personality. One picks Intel-style strobes (separate read and write strobes, an address latch enable, and a ready line) or Motorola-style strobes (a data strobe, a read/write direction bit, an address strobe, and an acknowledge line). The other picks whether the address travels on the data bus or on a separate address bus.

The host bus is asynchronous to the block clock. Every bus input passes through a two-stage synchroniser. Edges of the synchronised strobes then become single-cycle pulses, which latch the address, commit write data, and enable the read driver. The bidirectional bus appears as separate data-in, data-out and output-enable signals. The handshake line appears the same way: a value plus an enable.

Top module: `hostPort`

## Requirements
- R1: After reset, every register reads 0 and `dataOe` is 0. In Intel style (`modeIntel`=1) `ackOe` is 0. In Motorola style `ackOe` is 1 and `ackOut` is 0.
- R2: Only the low five address bits are decoded. An access to address 0xE7 reaches the same register as address 0x07.
- R3: In Intel style with the separate address bus (`muxBus`=0), a write commits `dataIn` to the register addressed by `addrBus` when `wrRw` (write strobe, active low) returns high while `csN` is low.
- R4: During a read, `dataOe` is 1 and `dataOut` holds the addressed register while the read strobe is low and `csN` is low. `dataOe` returns to 0 after the strobe goes high.
- R5: With `muxBus`=1, the address is taken from `dataIn` on the falling edge of `aleAs`. Later bus values do not change the addressed register.
- R6: In Motorola style, `rdDs` is the active-low data strobe and `wrRw` is the direction bit (1 = read, 0 = write). A write commits when the data strobe rises.
- R7: In Intel style the ready line is released (`ackOe`=0) when idle. It is driven 0 once `csN` is low and driven 1 after the transfer strobe rises. It is released again once `csN` rises.
- R8: In Motorola style the acknowledge line goes to 1 once the address has been received and `csN` is low, and returns to 0 once the data strobe has risen.
- R9: Strobes given while `csN` is high change no register and leave `dataOe` at 0.
- R10: The committed write value is the bus value present while the write strobe was low. A bus change at the same instant as the strobe's rising edge is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| modeIntel | input | 1 | Strap: 1 Intel-style strobes, 0 Motorola-style |
| muxBus | input | 1 | Strap: 1 address on data bus, 0 separate address bus |
| csN | input | 1 | Chip select, active low |
| aleAs | input | 1 | Address latch enable / address strobe, address taken on falling edge |
| rdDs | input | 1 | Intel read strobe / Motorola data strobe, active low |
| wrRw | input | 1 | Intel write strobe (active low) / Motorola direction (1 read) |
| addrBus | input | 8 | Separate address bus |
| dataIn | input | 8 | Bus value driven by the host |
| dataOut | output | 8 | Read data for the bus |
| dataOe | output | 1 | Enable for the read driver |
| ackOut | output | 1 | Ready / acknowledge value |
| ackOe | output | 1 | Enable for the ready / acknowledge driver |

## Verification
Directed cycles visit all four personalities. Each one writes and reads back a distinct value, so a misplaced strap decode shows up as wrong data or a wrong handshake level. Corner cases cover the following:
- An address above 0x1F, to check that it aliases onto the low registers.
- Strobes given with chip select high, to check that the write is blocked.
- A multiplexed cycle whose bus changes after the address phase, to check that the address is held.
- A write whose data flips at the rising strobe, to check when the data is captured.

A seeded random run then mixes personalities, addresses and directions against a bench memory model. This exposes crosstalk between registers and wrong address capture.

// File: rtl/hostPortPkg.sv
package hostPortPkg;
  typedef struct packed {
    logic addrLatch;  // capture address into datapath
    logic dataHold;   // transfer strobe active: track bus data
    logic wrCommit;   // write the held data into the addressed register
    logic rdEnable;   // read phase active
  } hpStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SEL  = 2'd1,
    PH_DONE = 2'd2
  } hpPhase_t;
endpackage

// File: rtl/hpSyncBank.sv
module hpSyncBank #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RESET_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/hpCtrl.sv
module hpCtrl
  import hostPortPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeIntel,
  input  logic       muxBus,
  input  logic       csNS,
  input  logic       aleS,
  input  logic       rdDsS,
  input  logic       wrRwS,
  output hpStrobes_t strobes,
  output logic       ackOut,
  output logic       ackOe
);
  logic csA, strbA, strbP, isReadNow, isReadQ;
  logic strbLead, strbTrail, aleP, aleFall, addrSeen;
  hpPhase_t phase, phaseNext;

  assign csA       = ~csNS;
  assign strbA     = modeIntel ? (~rdDsS | ~wrRwS) : ~rdDsS;
  assign isReadNow = modeIntel ? ~rdDsS : wrRwS;
  assign strbLead  = strbA & ~strbP;
  assign strbTrail = ~strbA & strbP;
  assign aleFall   = ~aleS & aleP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strbP   <= 1'b0;
      aleP    <= 1'b0;
      isReadQ <= 1'b0;
    end else begin
      strbP <= strbA;
      aleP  <= aleS;
      if (strbLead) isReadQ <= isReadNow;
    end
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (csA && (modeIntel || !muxBus || addrSeen || aleFall)) phaseNext = PH_SEL;
      PH_SEL:  if (!csA) phaseNext = PH_IDLE;
               else if (strbTrail) phaseNext = PH_DONE;
      PH_DONE: if (!csA) phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      addrSeen <= 1'b0;
    end else begin
      phase <= phaseNext;
      if (phase != PH_IDLE && phaseNext == PH_IDLE) addrSeen <= 1'b0;
      else if (aleFall) addrSeen <= 1'b1;
    end
  end

  assign strobes.addrLatch = muxBus ? aleFall : (csA & strbLead);
  assign strobes.dataHold  = strbA;
  assign strobes.wrCommit  = csA & strbTrail & ~isReadQ;
  assign strobes.rdEnable  = csA & strbA & isReadNow;

  assign ackOe  = modeIntel ? (phase != PH_IDLE) : 1'b1;
  assign ackOut = modeIntel ? (phase == PH_DONE) : (phase == PH_SEL);

  // R3: commit is a single-cycle pulse
  p_commit_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCommit |=> !strobes.wrCommit);

  // R7: completion is only reached from the selected phase
  p_done_from_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && $past(phase) != PH_DONE) |-> $past(phase) == PH_SEL);

  // R7: releasing chip select always returns the handshake to idle
  p_idle_after_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !csA) |=> phase == PH_IDLE);
endmodule

// File: rtl/hpRegFile.sv
module hpRegFile
  import hostPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W = 8,
  parameter int NUM_REGS = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              muxBus,
  input  hpStrobes_t        strobes,
  input  logic [DATA_W-1:0] dataInS,
  input  logic [BUS_W-1:0]  addrBusS,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [ADDR_W-1:0] addrQ, addrSrc;
  logic [DATA_W-1:0] wrHold;
  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic              oeQ;

  assign addrSrc = muxBus ? dataInS[ADDR_W-1:0] : addrBusS[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wrHold <= '0;
      oeQ    <= 1'b0;
    end else begin
      if (strobes.addrLatch) addrQ <= addrSrc;
      if (strobes.dataHold) wrHold <= dataInS;
      oeQ <= strobes.rdEnable;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ[g] <= '0;
      else if (strobes.wrCommit && addrQ == ADDR_W'(g)) regQ[g] <= wrHold;
    end
  end

  assign dataOut = regQ[addrQ];
  assign dataOe  = oeQ;

  // R5: address holds between latch pulses
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.addrLatch |=> $stable(addrQ));

  // R4: read data stays steady while it is driven
  p_read_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(dataOe) && !$past(strobes.wrCommit) && !$past(strobes.addrLatch))
      |-> $stable(dataOut));
endmodule

// File: rtl/hostPort.sv
module hostPort
  import hostPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W = 8,
  parameter int NUM_REGS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeIntel,
  input  logic              muxBus,
  input  logic              csN,
  input  logic              aleAs,
  input  logic              rdDs,
  input  logic              wrRw,
  input  logic [BUS_W-1:0]  addrBus,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ackOut,
  output logic              ackOe
);
  localparam int SYNC_W = 4 + BUS_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1011, {(BUS_W + DATA_W){1'b0}}};

  logic [SYNC_W-1:0] rawIn, syncOut;
  logic              csNS, aleS, rdDsS, wrRwS;
  logic [BUS_W-1:0]  addrBusS;
  logic [DATA_W-1:0] dataInS;
  hpStrobes_t        strobes;

  assign rawIn = {csN, aleAs, rdDs, wrRw, addrBus, dataIn};
  assign {csNS, aleS, rdDsS, wrRwS, addrBusS, dataInS} = syncOut;

  hpSyncBank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncOut));

  hpCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .modeIntel(modeIntel), .muxBus(muxBus),
    .csNS(csNS), .aleS(aleS), .rdDsS(rdDsS), .wrRwS(wrRwS),
    .strobes(strobes), .ackOut(ackOut), .ackOe(ackOe));

  hpRegFile #(.DATA_W(DATA_W), .BUS_W(BUS_W), .NUM_REGS(NUM_REGS)) i_regs (
    .clk(clk), .rstN(rstN), .muxBus(muxBus), .strobes(strobes),
    .dataInS(dataInS), .addrBusS(addrBusS), .dataOut(dataOut), .dataOe(dataOe));
endmodule

// File: tb/test_hostPort.sv
module test_hostPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeIntel = 1'b1, muxBus = 1'b0;
  logic csN = 1'b1, aleAs = 1'b0, rdDs = 1'b1, wrRw = 1'b1;
  logic [7:0] addrBus = '0, dataIn = '0;
  logic [7:0] dataOut;
  logic dataOe, ackOut, ackOe;

  int nTests = 0, nFails = 0;
  bit finished = 0;
  logic [7:0] mem [32];
  localparam int W = 6;

  always #2.5 clk = ~clk;

  hostPort i_hostPort (
    .clk(clk), .rstN(rstN), .modeIntel(modeIntel), .muxBus(muxBus),
    .csN(csN), .aleAs(aleAs), .rdDs(rdDs), .wrRw(wrRw), .addrBus(addrBus),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe), .ackOut(ackOut), .ackOe(ackOe));

  function automatic logic [7:0] expRead(input logic [7:0] a);
    return mem[a[4:0]];
  endfunction

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  // one bus cycle in the current personality
  task automatic busCycle(input bit isRead, input logic [7:0] a, input logic [7:0] d,
                          input bit csOn, input bit twist, output logic [7:0] rd);
    rd = '0;
    if (muxBus) begin
      dataIn = a; aleAs = 1'b1; waitN(W);
      aleAs = 1'b0; waitN(W);
    end else addrBus = a;
    if (csOn) csN = 1'b0;
    waitN(W);
    if (csOn) begin
      if (modeIntel) check(ackOe === 1'b1 && ackOut === 1'b0, "R7 select", {6'b0, ackOe, ackOut}, 8'h2);
      else check(ackOe === 1'b1 && ackOut === 1'b1, "R8 address seen", {6'b0, ackOe, ackOut}, 8'h3);
    end
    if (!isRead) dataIn = d;
    else if (muxBus) dataIn = ~a;  // R5: bus moves on after address phase
    if (!modeIntel) wrRw = isRead;
    waitN(2);
    if (modeIntel) begin
      if (isRead) rdDs = 1'b0; else wrRw = 1'b0;
    end else rdDs = 1'b0;
    waitN(W);
    if (isRead) begin
      rd = dataOut;
      if (csOn) check(dataOe === 1'b1, "R4 drive during read", {7'b0, dataOe}, 8'h1);
    end
    if (!csOn) check(dataOe === 1'b0, "R9 no drive without select", {7'b0, dataOe}, 8'h0);
    rdDs = 1'b1;
    if (modeIntel) wrRw = 1'b1;
    if (twist) dataIn = ~d;
    waitN(W);
    check(dataOe === 1'b0, "R4 release after strobe", {7'b0, dataOe}, 8'h0);
    if (csOn) begin
      if (modeIntel) check(ackOe === 1'b1 && ackOut === 1'b1, "R7 done", {6'b0, ackOe, ackOut}, 8'h3);
      else check(ackOut === 1'b0, "R8 done", {7'b0, ackOut}, 8'h0);
    end
    csN = 1'b1; wrRw = 1'b1;
    waitN(W);
    if (modeIntel) check(ackOe === 1'b0, "R7 released", {7'b0, ackOe}, 8'h0);
    else check(ackOe === 1'b1 && ackOut === 1'b0, "R8 idle", {6'b0, ackOe, ackOut}, 8'h2);
    if (!isRead && csOn) mem[a[4:0]] = d;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] rd;
    busCycle(1'b0, a, d, 1'b1, 1'b0, rd);
  endtask

  task automatic doReadCheck(input logic [7:0] a, input string req);
    logic [7:0] rd;
    busCycle(1'b1, a, 8'h00, 1'b1, 1'b0, rd);
    check(rd === expRead(a), req, rd, expRead(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    void'($urandom(32'd20250611));
    waitN(4);
    rstN = 1'b1;
    waitN(4);
    // R1: reset state
    check(dataOe === 1'b0, "R1 oe idle", {7'b0, dataOe}, 8'h0);
    check(ackOe === 1'b0, "R1 intel ready released", {7'b0, ackOe}, 8'h0);
    modeIntel = 1'b0; waitN(1);
    check(ackOe === 1'b1 && ackOut === 1'b0, "R1 motorola ack low", {6'b0, ackOe, ackOut}, 8'h2);
    modeIntel = 1'b1;
    doReadCheck(8'h00, "R1 reg0 zero");
    doReadCheck(8'h1F, "R1 reg31 zero");

    // R3: Intel, separate address bus
    modeIntel = 1'b1; muxBus = 1'b0;
    doWrite(8'h04, 8'hA5);
    doReadCheck(8'h04, "R3 intel write readback");
    // R2: alias of upper address bits
    doWrite(8'hE7, 8'h3C);
    doReadCheck(8'h07, "R2 address alias");
    // R5: Intel multiplexed
    muxBus = 1'b1;
    doWrite(8'h11, 8'h5A);
    doReadCheck(8'h11, "R5 intel mux readback");
    // R6: Motorola separate and multiplexed
    modeIntel = 1'b0; muxBus = 1'b0;
    doWrite(8'h09, 8'hC3);
    doReadCheck(8'h09, "R6 motorola write readback");
    muxBus = 1'b1;
    doWrite(8'h1E, 8'h81);
    doReadCheck(8'h1E, "R6 motorola mux readback");
    // R9: no chip select, no effect
    modeIntel = 1'b1; muxBus = 1'b0;
    busCycle(1'b0, 8'h04, 8'hFF, 1'b0, 1'b0, rd);
    doReadCheck(8'h04, "R9 unselected write ignored");
    modeIntel = 1'b0; muxBus = 1'b1;
    busCycle(1'b0, 8'h09, 8'h00, 1'b0, 1'b0, rd);
    doReadCheck(8'h09, "R9 unselected motorola write ignored");
    // R10: data flips exactly as the strobe rises
    modeIntel = 1'b1; muxBus = 1'b0;
    busCycle(1'b0, 8'h02, 8'h96, 1'b1, 1'b1, rd);
    doReadCheck(8'h02, "R10 data at strobe rise");

    // random mix of personalities
    for (int k = 0; k < 80; k++) begin
      logic [7:0] a, d;
      bit isRd;
      modeIntel = $urandom % 2;
      muxBus = $urandom % 2;
      a = 8'($urandom);
      d = 8'($urandom);
      isRd = ($urandom % 3) == 0;
      if (isRd) doReadCheck(a, "R6 random read");
      else doWrite(a, d);
    end
    for (int i = 0; i < 32; i++) doReadCheck(8'(i), "R2 final sweep");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule